// File: doc/BRIEF.md
# Parallel NOR Flash Command Sequencer

This block models the control side of a parallel NOR flash behind a simple synchronous strobe bus. Reads behave like a RAM: with the chip selected and output enabled, the word held at the presented address appears on the read data port with no preceding command. Writes are never stored as they arrive. Each write strobe instead feeds a command sequencer. The sequencer watches for the two-write unlock handshake, followed by an operation code. It then programs one word, erases one sector or erases the whole cell array.

The array is small and set by parameters. Only the low address bits select a cell, so upper addresses alias onto the array. The command addresses are compared against the full address bus. Programming can only pull bits low, and an erase is the only way to bring them back to ones. After each program or erase, a busy window of a fixed length blocks further writes.

Top module: `nor_cmd_ctrl`

## Requirements
- R1: After reset every cell holds all ones and `busy` is low.
- R2: While `cs` and `oe` are high and `we` is low, `rdata` shows the word at cell index `addr[IDX_W-1:0]` in the same cycle. At all other times `rdata` is zero.
- R3: A write is one cycle with `cs` and `we` both high. The program sequence is four writes: 0x00AA to 0x5555, then 0x0055 to 0x2AAA, then 0x00A0 to 0x5555, then a data write to the target address. That last write stores data at the target cell on the clock edge that samples it.
- R4: A program sets the cell to the old value ANDed with the written data, so no bit can rise from 0 to 1.
- R5: The chip erase sequence is six writes: 0x00AA to 0x5555, 0x0055 to 0x2AAA, 0x0080 to 0x5555, 0x00AA to 0x5555, 0x0055 to 0x2AAA, and 0x0010 to 0x5555. It sets every cell to all ones.
- R6: The sector erase sequence has the same first five writes as R5, followed by 0x0030 to any address. It sets only the cells whose sector number `addr[IDX_W-1:log2(SECT_WORDS)]` matches that address to all ones.
- R7: A write that does not match the next expected address and code returns the sequencer to idle and leaves the array unchanged.
- R8: `busy` rises on the clock edge that commits a program or erase and stays high for exactly BUSY_CYC cycles. Writes sampled while `busy` is high are ignored entirely.
- R9: A command code is compared against the whole data word, so its upper byte must be zero. A word such as 0x01AA does not count as an unlock write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cs | input | 1 | Chip select |
| we | input | 1 | Write strobe, one write per sampled cycle |
| oe | input | 1 | Output enable for reads |
| addr | input | ADDR_W | Word address |
| wdata | input | DATA_W | Write data or command word |
| rdata | output | DATA_W | Read data, zero when not reading |
| busy | output | 1 | High while a program or erase window is open |

## Verification
Two events can land on the same clock edge: the last cycle of the busy window and the first write of a new unlock handshake. The bench places an 0x00AA write exactly on the final busy cycle and follows it with the rest of a program sequence. The target cell must then read back unchanged. A second run starts the same sequence one cycle later, and that program must take effect. A read issued on the cycle straight after an erase commit is also checked, so the erase result is confirmed to be visible at once.

// File: rtl/nor_pkg.sv
package nor_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_UNL1,
        ST_UNL2,
        ST_PROG,
        ST_ERS1,
        ST_ERS2,
        ST_ERS3
    } seq_e;

    typedef enum logic [1:0] {
        OP_NONE,
        OP_PROG,
        OP_CHIP,
        OP_SECT
    } op_e;

    localparam logic [7:0] CODE_KEY1  = 8'hAA;
    localparam logic [7:0] CODE_KEY2  = 8'h55;
    localparam logic [7:0] CODE_PROG  = 8'hA0;
    localparam logic [7:0] CODE_ERASE = 8'h80;
    localparam logic [7:0] CODE_CHIP  = 8'h10;
    localparam logic [7:0] CODE_SECT  = 8'h30;

    localparam logic [31:0] KEY1_ADDR = 32'h0000_5555;
    localparam logic [31:0] KEY2_ADDR = 32'h0000_2AAA;

    // Full-word compare: upper bits of a command word must be zero.
    function automatic logic code_hit(input logic [31:0] word, input logic [7:0] code);
        return word == {24'h0, code};
    endfunction

endpackage

// File: rtl/nor_seq_fsm.sv
module nor_seq_fsm
    import nor_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output op_e               op_kind
);

    seq_e state_q, state_d;
    logic at_key1, at_key2;
    logic [31:0] word32;

    assign at_key1 = (32'(addr) == KEY1_ADDR);
    assign at_key2 = (32'(addr) == KEY2_ADDR);
    assign word32  = 32'(wdata);

    always_comb begin
        state_d = state_q;
        op_kind = OP_NONE;
        if (wr_en) begin
            state_d = ST_IDLE;
            unique case (state_q)
                ST_IDLE: if (at_key1 && code_hit(word32, CODE_KEY1)) state_d = ST_UNL1;
                ST_UNL1: if (at_key2 && code_hit(word32, CODE_KEY2)) state_d = ST_UNL2;
                ST_UNL2: begin
                    if (at_key1 && code_hit(word32, CODE_PROG))       state_d = ST_PROG;
                    else if (at_key1 && code_hit(word32, CODE_ERASE)) state_d = ST_ERS1;
                end
                ST_PROG: op_kind = OP_PROG;
                ST_ERS1: if (at_key1 && code_hit(word32, CODE_KEY1)) state_d = ST_ERS2;
                ST_ERS2: if (at_key2 && code_hit(word32, CODE_KEY2)) state_d = ST_ERS3;
                ST_ERS3: begin
                    if (at_key1 && code_hit(word32, CODE_CHIP)) op_kind = OP_CHIP;
                    else if (code_hit(word32, CODE_SECT))       op_kind = OP_SECT;
                end
                default: state_d = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

endmodule

// File: rtl/nor_busy_timer.sv
module nor_busy_timer #(
    parameter int BUSY_CYC = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic busy
);

    localparam int CNT_W = $clog2(BUSY_CYC + 1);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)              cnt_q <= '0;
        else if (start)       cnt_q <= CNT_W'(BUSY_CYC);
        else if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
    end

    assign busy = (cnt_q != '0);

endmodule

// File: rtl/nor_cell_array.sv
module nor_cell_array
    import nor_pkg::*;
#(
    parameter int ADDR_W     = 16,
    parameter int DATA_W     = 16,
    parameter int DEPTH      = 64,
    parameter int SECT_WORDS = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  op_e               op_kind,
    input  logic [ADDR_W-1:0] op_addr,
    input  logic [DATA_W-1:0] op_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_word
);

    localparam int IDX_W   = $clog2(DEPTH);
    localparam int SECT_LG = $clog2(SECT_WORDS);
    localparam int SID_W   = IDX_W - SECT_LG;

    logic [DEPTH*DATA_W-1:0] flat;
    logic [IDX_W-1:0]        op_idx, rd_idx;
    logic [SID_W-1:0]        op_sid;

    assign op_idx = op_addr[IDX_W-1:0];
    assign op_sid = op_addr[IDX_W-1:SECT_LG];
    assign rd_idx = rd_addr[IDX_W-1:0];

    for (genvar i = 0; i < DEPTH; i++) begin : g_cell
        localparam logic [SID_W-1:0] MY_SID = SID_W'(i / SECT_WORDS);
        localparam logic [IDX_W-1:0] MY_IDX = IDX_W'(i);
        logic [DATA_W-1:0] word_q;

        always_ff @(posedge clk) begin
            if (rst) begin
                word_q <= '1;
            end else begin
                case (op_kind)
                    OP_CHIP: word_q <= '1;
                    OP_SECT: if (op_sid == MY_SID) word_q <= '1;
                    OP_PROG: if (op_idx == MY_IDX) word_q <= word_q & op_data;
                    default: ;
                endcase
            end
        end

        assign flat[i*DATA_W +: DATA_W] = word_q;
    end

    assign rd_word = flat[rd_idx*DATA_W +: DATA_W];

endmodule

// File: rtl/nor_cmd_ctrl.sv
module nor_cmd_ctrl
    import nor_pkg::*;
#(
    parameter int ADDR_W     = 16,
    parameter int DATA_W     = 16,
    parameter int DEPTH      = 64,
    parameter int SECT_WORDS = 16,
    parameter int BUSY_CYC   = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cs,
    input  logic              we,
    input  logic              oe,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              busy
);

    op_e               op_kind;
    logic              wr_en;
    logic [DATA_W-1:0] cell_word;

    assign wr_en = cs && we && !busy;

    nor_seq_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_fsm (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .addr    (addr),
        .wdata   (wdata),
        .op_kind (op_kind)
    );

    nor_busy_timer #(.BUSY_CYC(BUSY_CYC)) u_timer (
        .clk   (clk),
        .rst   (rst),
        .start (op_kind != OP_NONE),
        .busy  (busy)
    );

    nor_cell_array #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEPTH(DEPTH), .SECT_WORDS(SECT_WORDS)
    ) u_array (
        .clk     (clk),
        .rst     (rst),
        .op_kind (op_kind),
        .op_addr (addr),
        .op_data (wdata),
        .rd_addr (addr),
        .rd_word (cell_word)
    );

    assign rdata = (cs && oe && !we) ? cell_word : '0;

endmodule

// File: rtl/nor_cmd_ctrl_chk.sv
module nor_cmd_ctrl_chk
    import nor_pkg::*;
#(
    parameter int ADDR_W     = 16,
    parameter int DATA_W     = 16,
    parameter int DEPTH      = 64,
    parameter int SECT_WORDS = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              cs,
    input logic              we,
    input logic              oe,
    input logic [ADDR_W-1:0] addr,
    input logic [DATA_W-1:0] rdata,
    input logic              busy,
    input op_e               op_kind
);

    localparam int IDX_W   = $clog2(DEPTH);
    localparam int SECT_LG = $clog2(SECT_WORDS);

    logic rd_act;
    assign rd_act = cs && oe && !we;

    // R1: the cycle after reset leaves no busy window open
    always_ff @(posedge clk) begin
        if (!rst && $past(rst)) begin
            a_r1_idle_after_reset: assert (!busy);
        end
    end

    a_r8_quiet_while_busy: assert property (@(posedge clk) disable iff (rst)
        busy |-> op_kind == OP_NONE);

    a_r8_busy_after_op: assert property (@(posedge clk) disable iff (rst)
        (op_kind != OP_NONE) |=> busy);

    a_r5_chip_reads_ones: assert property (@(posedge clk) disable iff (rst)
        ($past(op_kind) == OP_CHIP && rd_act) |-> rdata == '1);

    a_r6_sector_reads_ones: assert property (@(posedge clk) disable iff (rst)
        ($past(op_kind) == OP_SECT && rd_act &&
         addr[IDX_W-1:SECT_LG] == $past(addr[IDX_W-1:SECT_LG])) |-> rdata == '1);

    a_r2_read_stable: assert property (@(posedge clk) disable iff (rst)
        (rd_act && $past(rd_act) && addr == $past(addr)) |-> $stable(rdata));

endmodule

bind nor_cmd_ctrl nor_cmd_ctrl_chk #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEPTH(DEPTH), .SECT_WORDS(SECT_WORDS)
) u_chk (
    .clk     (clk),
    .rst     (rst),
    .cs      (cs),
    .we      (we),
    .oe      (oe),
    .addr    (addr),
    .rdata   (rdata),
    .busy    (busy),
    .op_kind (op_kind)
);

// File: tb/test_nor_cmd_ctrl.sv
`timescale 1ns/1ps
module test_nor_cmd_ctrl;

    localparam int BUSY_CYC = 8;
    localparam int DEPTH    = 64;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cs = 1'b0, we = 1'b0, oe = 1'b0;
    logic [15:0] addr = '0, wdata = '0;
    logic [15:0] rdata;
    logic        busy;

    int n_chk = 0;
    int n_fail = 0;
    logic [15:0] mdl [DEPTH];

    typedef struct {
        logic [15:0] a;
        logic [15:0] e;
        string       tag;
    } rd_item_t;
    rd_item_t exp_q[$];

    always #2.5 clk = ~clk;

    nor_cmd_ctrl #(.BUSY_CYC(BUSY_CYC)) i_nor_cmd_ctrl (
        .clk(clk), .rst(rst), .cs(cs), .we(we), .oe(oe),
        .addr(addr), .wdata(wdata), .rdata(rdata), .busy(busy)
    );

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Monitor: pops the expected read item and compares shortly after the edge.
    initial begin
        forever begin
            @(posedge clk);
            if (cs && oe && !we) begin
                #1;
                if (exp_q.size() == 0) begin
                    check("scoreboard empty", 16'h0, 16'h1);
                end else begin
                    rd_item_t it;
                    it = exp_q.pop_front();
                    check(it.tag, rdata, it.e);
                end
            end
        end
    end

    // All tasks start and end at a falling edge.
    task automatic wr(input logic [15:0] a, input logic [15:0] d);
        cs = 1; we = 1; addr = a; wdata = d;
        @(negedge clk);
        cs = 0; we = 0;
    endtask

    task automatic rd(input logic [15:0] a, input string tag);
        rd_item_t it;
        it.a = a; it.e = mdl[a[5:0]]; it.tag = tag;
        exp_q.push_back(it);
        cs = 1; oe = 1; addr = a;
        @(negedge clk);
        cs = 0; oe = 0;
    endtask

    task automatic unlock();
        wr(16'h5555, 16'h00AA);
        wr(16'h2AAA, 16'h0055);
    endtask

    task automatic prog(input logic [15:0] a, input logic [15:0] d);
        unlock();
        wr(16'h5555, 16'h00A0);
        wr(a, d);
        mdl[a[5:0]] = mdl[a[5:0]] & d;
    endtask

    task automatic erase_pre();
        unlock();
        wr(16'h5555, 16'h0080);
        unlock();
    endtask

    task automatic wait_idle();
        while (busy) @(negedge clk);
    endtask

    initial begin
        for (int i = 0; i < DEPTH; i++) mdl[i] = 16'hFFFF;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);

        // R1: reset state
        check("R1 busy after reset", {15'h0, busy}, 16'h0);
        rd(16'h0000, "R1 cell 0 erased");
        rd(16'h003F, "R1 cell 63 erased");
        // R2: no output without oe
        cs = 1; addr = 16'h0003;
        #1 check("R2 rdata gated", rdata, 16'h0000);
        cs = 0;
        @(negedge clk);

        // R3 program and R8 busy length
        prog(16'h0003, 16'h1234);
        begin
            int n = 0;
            while (busy) begin n++; @(negedge clk); end
            check("R8 busy length", 16'(n), 16'(BUSY_CYC));
        end
        rd(16'h0003, "R3 programmed word");

        // R4 AND semantics
        prog(16'h0003, 16'hFF00); wait_idle();
        rd(16'h0003, "R4 bits only clear");
        prog(16'h0020, 16'h0F0F); wait_idle();
        rd(16'h0020, "R3 second word");

        // R7 broken handshake
        wr(16'h5555, 16'h00AA); wr(16'h2AAA, 16'h0056);
        wr(16'h5555, 16'h00A0); wr(16'h0005, 16'h0000);
        check("R7 no busy on broken seq", {15'h0, busy}, 16'h0);
        rd(16'h0005, "R7 cell untouched");
        unlock(); wr(16'h5555, 16'h0080); wr(16'h5555, 16'h0077);
        erase_pre(); wr(16'h1234, 16'h0031);
        rd(16'h0003, "R7 bad erase code keeps data");

        // R9 upper byte must be zero
        wr(16'h5555, 16'h01AA); wr(16'h2AAA, 16'h0055);
        wr(16'h5555, 16'h00A0); wr(16'h0006, 16'h0000);
        rd(16'h0006, "R9 wide code rejected");

        // R8 write on the last busy cycle is ignored
        prog(16'h0007, 16'h00FF);
        repeat (7) @(negedge clk);
        check("R8 still busy on last cycle", {15'h0, busy}, 16'h1);
        wr(16'h5555, 16'h00AA);
        wr(16'h2AAA, 16'h0055); wr(16'h5555, 16'h00A0); wr(16'h0008, 16'h0000);
        rd(16'h0008, "R8 write in busy ignored");
        rd(16'h0007, "R8 program before busy");
        // R8 first cycle after busy is accepted
        prog(16'h0009, 16'h00F0);
        repeat (8) @(negedge clk);
        check("R8 busy gone", {15'h0, busy}, 16'h0);
        prog(16'h000A, 16'h5A5A); wait_idle();
        rd(16'h000A, "R8 accepted after busy");

        // R5 chip erase, read on the very next cycle
        erase_pre(); wr(16'h5555, 16'h0010);
        for (int i = 0; i < DEPTH; i++) mdl[i] = 16'hFFFF;
        rd(16'h0003, "R5 chip erase next cycle");
        wait_idle();
        rd(16'h0020, "R5 chip erase word 0x20");
        rd(16'h000A, "R5 chip erase word 0x0A");

        // R6 sector erase of sector 1 via aliased address
        prog(16'h0002, 16'h0000); wait_idle();
        prog(16'h0012, 16'h1111); wait_idle();
        prog(16'h001F, 16'h2222); wait_idle();
        prog(16'h0025, 16'h3333); wait_idle();
        erase_pre(); wr(16'h401A, 16'h0030);
        for (int i = 16; i < 32; i++) mdl[i] = 16'hFFFF;
        rd(16'h0012, "R6 sector word erased next cycle");
        wait_idle();
        rd(16'h001F, "R6 sector last word erased");
        rd(16'h0002, "R6 sector 0 kept");
        rd(16'h0025, "R6 sector 2 kept");

        repeat (3) @(negedge clk);
        check("scoreboard drained", 16'(exp_q.size()), 16'h0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(200000 * 5);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule